// File: doc/BRIEF.md
# CAN transmit buffer priority arbiter

This block decides which pending message a CAN controller hands to its bus-side engine next. Two groups of requesters compete: sixteen remote-frame request lines, raised by receive buffers that owe an answer to a remote frame, and eight transmit holding buffers, each with a send-request flag. Remote requests always win over the transmit buffers, and among themselves the lowest-numbered line goes first. Among the transmit buffers a run-time mode input picks either a rotating order, which gives every requesting buffer an equal share, or a fixed order in which buffer 0 always wins.

The winner is held in a registered grant (valid flag, a source-kind bit and an index). It stays frozen while the engine works on the frame. When the engine reports a completed frame, the grant is released and a one-cycle clear strobe goes to the winning source so that its request flag can be dropped. When the engine reports lost bus arbitration, the grant is released with no clear strobe, and the same message competes again. In both cases a fresh choice is made from the requests present at that time.

Top module: `can_tx_arbiter`

## Requirements
- R1: A synchronous active-low reset clears the grant valid output and clear strobes and sets the rotation pointer to buffer 0, so that with all eight transmit flags set in rotating mode the first grant is buffer 0.
- R2: While no remote line and no transmit flag is set, `grant_valid_o` stays low. A grant only ever names a source whose request was set on the clock edge that made it. When idle with requests pending, the grant appears on the next rising edge.
- R3: If any remote line is set, the grant goes to a remote line (`grant_rtr_o` = 1) before any transmit buffer, and to the lowest-numbered set line.
- R4: With `rr_mode_i` = 0 (fixed order) and no remote request, the grant goes to the lowest-numbered transmit buffer whose flag is set (`grant_rtr_o` = 0).
- R5: With `rr_mode_i` = 1 (rotating order) and no remote request, the grant goes to the first set buffer met when scanning upward from the rotation pointer and wrapping from 7 to 0.
- R6: While `grant_valid_o` is high and neither `xfer_done_i` nor `arb_lost_i` is high, the grant (valid, kind and index) holds unchanged, whatever the request inputs do.
- R7: `xfer_done_i` high while a grant is valid drops the grant on the next edge. In the same cycle it drives a single clear strobe bit, the one at the granted index of `clr_rtr_o` or `clr_tx_o`. For a transmit buffer it also moves the rotation pointer to the index after the granted one (7 wraps to 0). This holds in both modes.
- R8: `arb_lost_i` high while a grant is valid drops the grant on the next edge. No clear strobe is driven and the rotation pointer is not moved, so the same buffer is chosen again if nothing outranks it.
- R9: `xfer_done_i` and `arb_lost_i` have no effect while no grant is valid: no strobe, no grant and no pointer change. If both are high with a valid grant, the pair acts as a completed transmission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rr_mode_i | input | 1 | 1 = rotating order, 0 = fixed order for transmit buffers |
| tx_req_i | input | 8 | Send-request flags of the transmit buffers, bit i = buffer i |
| rtr_req_i | input | 16 | Remote-frame request lines, bit i = line i |
| xfer_done_i | input | 1 | Engine finished sending the granted frame |
| arb_lost_i | input | 1 | Engine lost bus arbitration for the granted frame |
| grant_valid_o | output | 1 | A grant is held |
| grant_rtr_o | output | 1 | 1 = granted source is a remote line, 0 = a transmit buffer |
| grant_idx_o | output | 4 | Index of the granted source |
| clr_tx_o | output | 8 | One-cycle clear strobe for the granted transmit buffer |
| clr_rtr_o | output | 16 | One-cycle clear strobe for the granted remote line |

## Verification
A grant is due one rising edge after the arbiter sees pending requests while idle. After a completion or a lost arbitration it falls on the next edge, and any new grant follows one edge later, so one idle cycle always sits between grants. The clear strobes are combinational in the cycle the completion input is high. The bench drives inputs at falling edges, reads registered outputs at the next falling edge, and reads the strobes a short delay after driving the completion input. The driver pushes each expected grant into a queue as it sets up the requests that will produce it. A monitor pops and compares the entry on each rising edge of the grant valid flag.

// File: rtl/can_arb_pkg.sv
package can_arb_pkg;

  // widest request group the scan helper accepts
  localparam int unsigned ScanMax = 32;

  // Cyclic scan: first set bit of v at or after start, wrapping at n.
  // Returns -1 when no bit below n is set.
  function automatic int scan_from(logic [ScanMax-1:0] v, int n, int start);
    int found;
    int pos;
    found = -1;
    for (int k = 0; k < ScanMax; k++) begin
      if (k < n && found < 0) begin
        pos = start + k;
        if (pos >= n) pos = pos - n;
        if (v[pos[4:0]]) found = pos;
      end
    end
    return found;
  endfunction

  // Slot after cur in a ring of n slots.
  function automatic int next_slot(int cur, int n);
    return (cur + 1 >= n) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/can_arb_scan.sv
module can_arb_scan #(
  parameter int N  = 8,
  localparam int PW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  input  logic [PW-1:0] start,
  output logic          hit,
  output logic [PW-1:0] idx
);
  import can_arb_pkg::*;

  int pick;

  always_comb begin
    pick = scan_from(ScanMax'(req), N, int'(start));
    hit  = (pick >= 0);
    idx  = hit ? PW'(pick) : '0;
  end

endmodule

// File: rtl/can_arb_strobe.sv
module can_arb_strobe #(
  parameter int N  = 8,
  parameter int IW = 4
) (
  input  logic          en,
  input  logic [IW-1:0] idx,
  output logic [N-1:0]  strobe
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign strobe[i] = en && (int'(idx) == i);
  end
endmodule

// File: rtl/can_arb_core.sv
module can_arb_core #(
  parameter int N_TX = 8,
  parameter int IW   = 4,
  localparam int TXW = $clog2(N_TX)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cand_valid,
  input  logic           cand_rtr,
  input  logic [IW-1:0]  cand_idx,
  input  logic           done_in,
  input  logic           lost_in,
  output logic           grant_valid,
  output logic           grant_rtr,
  output logic [IW-1:0]  grant_idx,
  output logic [TXW-1:0] rr_ptr,
  output logic           evt_launch,
  output logic           evt_done,
  output logic           evt_lost,
  output logic           evt_advance
);
  import can_arb_pkg::*;

  // named events: done outranks lost when both arrive together
  assign evt_launch  = !grant_valid && cand_valid;
  assign evt_done    = grant_valid && done_in;
  assign evt_lost    = grant_valid && lost_in && !done_in;
  assign evt_advance = evt_done && !grant_rtr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant_valid <= 1'b0;
      grant_rtr   <= 1'b0;
      grant_idx   <= '0;
      rr_ptr      <= '0;
    end else begin
      if (evt_done || evt_lost) begin
        grant_valid <= 1'b0;
      end else if (evt_launch) begin
        grant_valid <= 1'b1;
        grant_rtr   <= cand_rtr;
        grant_idx   <= cand_idx;
      end
      if (evt_advance) begin
        rr_ptr <= TXW'(next_slot(int'(grant_idx), N_TX));
      end
    end
  end

endmodule

// File: rtl/can_tx_arbiter.sv
module can_tx_arbiter #(
  parameter int N_TX  = 8,
  parameter int N_RTR = 16,
  localparam int TXW = $clog2(N_TX),
  localparam int RTW = $clog2(N_RTR),
  localparam int IW  = (RTW > TXW) ? RTW : TXW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rr_mode_i,
  input  logic [N_TX-1:0]  tx_req_i,
  input  logic [N_RTR-1:0] rtr_req_i,
  input  logic             xfer_done_i,
  input  logic             arb_lost_i,
  output logic             grant_valid_o,
  output logic             grant_rtr_o,
  output logic [IW-1:0]    grant_idx_o,
  output logic [N_TX-1:0]  clr_tx_o,
  output logic [N_RTR-1:0] clr_rtr_o
);

  logic           rtr_hit, tx_fix_hit, tx_rot_hit;
  logic [RTW-1:0] rtr_idx;
  logic [TXW-1:0] tx_fix_idx, tx_rot_idx;
  logic [TXW-1:0] rr_ptr;
  logic           tx_hit;
  logic [TXW-1:0] tx_idx;
  logic           cand_valid, cand_rtr;
  logic [IW-1:0]  cand_idx;
  logic           evt_launch, evt_done, evt_lost, evt_advance;

  // remote lines: ascending order, always scanned from 0
  can_arb_scan #(.N(N_RTR)) u_rtr_scan (
    .req(rtr_req_i), .start('0), .hit(rtr_hit), .idx(rtr_idx)
  );

  // transmit buffers, fixed order
  can_arb_scan #(.N(N_TX)) u_tx_fix (
    .req(tx_req_i), .start('0), .hit(tx_fix_hit), .idx(tx_fix_idx)
  );

  // transmit buffers, rotating order from the pointer
  can_arb_scan #(.N(N_TX)) u_tx_rot (
    .req(tx_req_i), .start(rr_ptr), .hit(tx_rot_hit), .idx(tx_rot_idx)
  );

  always_comb begin
    tx_hit     = rr_mode_i ? tx_rot_hit : tx_fix_hit;
    tx_idx     = rr_mode_i ? tx_rot_idx : tx_fix_idx;
    cand_valid = rtr_hit || tx_hit;
    cand_rtr   = rtr_hit;
    cand_idx   = rtr_hit ? IW'(rtr_idx) : IW'(tx_idx);
  end

  can_arb_core #(.N_TX(N_TX), .IW(IW)) u_core (
    .clk(clk), .rst_n(rst_n),
    .cand_valid(cand_valid), .cand_rtr(cand_rtr), .cand_idx(cand_idx),
    .done_in(xfer_done_i), .lost_in(arb_lost_i),
    .grant_valid(grant_valid_o), .grant_rtr(grant_rtr_o), .grant_idx(grant_idx_o),
    .rr_ptr(rr_ptr),
    .evt_launch(evt_launch), .evt_done(evt_done), .evt_lost(evt_lost),
    .evt_advance(evt_advance)
  );

  can_arb_strobe #(.N(N_TX), .IW(IW)) u_clr_tx (
    .en(evt_done && !grant_rtr_o), .idx(grant_idx_o), .strobe(clr_tx_o)
  );

  can_arb_strobe #(.N(N_RTR), .IW(IW)) u_clr_rtr (
    .en(evt_done && grant_rtr_o), .idx(grant_idx_o), .strobe(clr_rtr_o)
  );

endmodule

// File: rtl/can_tx_arbiter_chk.sv
module can_tx_arbiter_chk #(
  parameter int N_TX  = 8,
  parameter int N_RTR = 16,
  parameter int IW    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_TX-1:0]  tx_req_i,
  input logic [N_RTR-1:0] rtr_req_i,
  input logic             xfer_done_i,
  input logic             arb_lost_i,
  input logic             grant_valid_o,
  input logic             grant_rtr_o,
  input logic [IW-1:0]    grant_idx_o,
  input logic [N_TX-1:0]  clr_tx_o,
  input logic [N_RTR-1:0] clr_rtr_o,
  input logic             evt_launch
);
  logic [N_TX-1:0]  tx_prev;
  logic [N_RTR-1:0] rtr_prev;
  logic             won_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_prev  <= '0;
      rtr_prev <= '0;
    end else begin
      tx_prev  <= tx_req_i;
      rtr_prev <= rtr_req_i;
    end
  end

  always_comb begin
    won_req = 1'b0;
    for (int i = 0; i < N_RTR; i++)
      if (grant_rtr_o && int'(grant_idx_o) == i) won_req = rtr_prev[i];
    for (int i = 0; i < N_TX; i++)
      if (!grant_rtr_o && int'(grant_idx_o) == i) won_req = tx_prev[i];
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    !rst_n |=> !grant_valid_o);

  a_r2_quiet_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_valid_o && tx_req_i == '0 && rtr_req_i == '0) |=> !grant_valid_o);

  a_r2_launch_on_request: assert property (@(posedge clk) disable iff (!rst_n)
    evt_launch |=> grant_valid_o);

  a_r2_winner_requested: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_valid_o) |-> won_req);

  a_r3_remote_first: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(grant_valid_o) && !grant_rtr_o) |-> (rtr_prev == '0));

  a_r6_grant_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid_o && !xfer_done_i && !arb_lost_i)
      |=> (grant_valid_o && $stable(grant_idx_o) && $stable(grant_rtr_o)));

  a_r7_release_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid_o && xfer_done_i) |=> !grant_valid_o);

  a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({clr_tx_o, clr_rtr_o}));

  a_r7_strobe_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_tx_o != '0) || (clr_rtr_o != '0)) |-> (grant_valid_o && xfer_done_i));

  a_r8_release_on_lost: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid_o && arb_lost_i) |=> !grant_valid_o);

  a_r8_no_strobe_on_loss: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_lost_i && !xfer_done_i) |-> (clr_tx_o == '0 && clr_rtr_o == '0));

  a_r9_idle_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_valid_o |-> (clr_tx_o == '0 && clr_rtr_o == '0));

endmodule

bind can_tx_arbiter can_tx_arbiter_chk #(.N_TX(N_TX), .N_RTR(N_RTR), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_req_i(tx_req_i), .rtr_req_i(rtr_req_i),
  .xfer_done_i(xfer_done_i), .arb_lost_i(arb_lost_i),
  .grant_valid_o(grant_valid_o), .grant_rtr_o(grant_rtr_o), .grant_idx_o(grant_idx_o),
  .clr_tx_o(clr_tx_o), .clr_rtr_o(clr_rtr_o), .evt_launch(evt_launch)
);

// File: tb/can_tx_arbiter_tb.sv
`timescale 1ns/1ps
module can_tx_arbiter_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rr = 1'b0;
  logic [7:0]  tx_q = '0;
  logic [15:0] rtr_q = '0;
  logic        done_q = 1'b0;
  logic        lost_q = 1'b0;
  logic        g_valid, g_rtr;
  logic [3:0]  g_idx;
  logic [7:0]  clr_tx;
  logic [15:0] clr_rtr;

  int vectors = 0;
  int misses  = 0;
  int ptr_m   = 0;
  bit finished = 0;
  bit was_valid = 0;

  logic [4:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  can_tx_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .rr_mode_i(rr), .tx_req_i(tx_q), .rtr_req_i(rtr_q),
    .xfer_done_i(done_q), .arb_lost_i(lost_q),
    .grant_valid_o(g_valid), .grant_rtr_o(g_rtr), .grant_idx_o(g_idx),
    .clr_tx_o(clr_tx), .clr_rtr_o(clr_rtr)
  );

  task automatic check(input bit ok, input string what, input logic [31:0] act,
                       input logic [31:0] expv);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s: actual %h expected %h", what, act, expv);
    end
  endtask

  // reference choice: {remote kind, index}
  function automatic logic [4:0] model_pick(logic [15:0] r, logic [7:0] t, bit rot, int p);
    for (int i = 0; i < 16; i++) if (r[i]) return {1'b1, 4'(i)};
    if (rot) begin
      for (int k = 0; k < 8; k++) if (t[(p + k) % 8]) return {1'b0, 4'((p + k) % 8)};
    end else begin
      for (int i = 0; i < 8; i++) if (t[i]) return {1'b0, 4'(i)};
    end
    return 5'h1f;
  endfunction

  task automatic push_expect(input string tag);
    if (rtr_q != '0 || tx_q != '0) begin
      exp_q.push_back(model_pick(rtr_q, tx_q, rr, ptr_m));
      tag_q.push_back(tag);
    end
  endtask

  // monitor: compares each new grant with the queue head
  always @(negedge clk) begin
    if (rst_n) begin
      if (g_valid && !was_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 grant with no expectation", {27'd0, g_rtr, g_idx}, 32'h0);
        end else begin
          logic [4:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({g_rtr, g_idx} == e, t, {27'd0, g_rtr, g_idx}, {27'd0, e});
        end
      end
      was_valid = g_valid;
    end
  end

  task automatic post(input logic [15:0] r, input logic [7:0] t, input string tag);
    @(negedge clk);
    rtr_q = r;
    tx_q  = t;
    push_expect(tag);
  endtask

  task automatic wait_grant(input string tag);
    int n;
    n = 0;
    @(negedge clk);
    while (!g_valid && n < 20) begin
      @(negedge clk);
      n++;
    end
    check(g_valid == 1'b1, {tag, " grant due"}, {31'd0, g_valid}, 32'd1);
  endtask

  // end the held grant: lost-only, done-only, or both together
  task automatic finish(input bit lose, input bit both, input string tag);
    bit         eff_done;
    logic       kr;
    logic [3:0] ki;
    logic [7:0]  etx;
    logic [15:0] ertr;
    @(negedge clk);
    kr = g_rtr;
    ki = g_idx;
    eff_done = !lose || both;
    done_q = eff_done;
    lost_q = lose || both;
    #1;
    etx  = (eff_done && !kr) ? (8'h1 << ki) : 8'h0;
    ertr = (eff_done && kr) ? (16'h1 << ki) : 16'h0;
    check(clr_tx == etx, {tag, " tx strobe"}, {24'd0, clr_tx}, {24'd0, etx});
    check(clr_rtr == ertr, {tag, " remote strobe"}, {16'd0, clr_rtr}, {16'd0, ertr});
    @(negedge clk);
    done_q = 1'b0;
    lost_q = 1'b0;
    check(g_valid == 1'b0, {tag, " release"}, {31'd0, g_valid}, 32'd0);
    if (eff_done) begin
      if (kr) rtr_q[ki] = 1'b0;
      else begin
        tx_q[ki[2:0]] = 1'b0;
        ptr_m = (int'(ki) + 1) % 8;
      end
    end
    push_expect(tag);
  endtask

  task automatic drain(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      wait_grant(tag);
      finish(1'b0, 1'b0, tag);
    end
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      misses++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs cleared during reset
    check(g_valid == 1'b0, "R1 reset valid", {31'd0, g_valid}, 32'd0);
    check(clr_tx == '0 && clr_rtr == '0, "R1 reset strobes", {8'd0, clr_rtr, clr_tx}, 32'd0);
    rst_n = 1'b1;

    // R2: nothing pending, grant stays low
    repeat (4) begin
      @(negedge clk);
      check(g_valid == 1'b0, "R2 idle low", {31'd0, g_valid}, 32'd0);
    end

    // R1/R5: rotating order from buffer 0 after reset
    rr = 1'b1;
    post(16'h0, 8'hFF, "R1 R5 first after reset");
    wait_grant("R5");
    finish(1'b0, 1'b0, "R5 rotation");
    drain(7, "R5 rotation");

    // R5: wrap of the scan past buffer 7
    post(16'h0, 8'h05, "R5 wrap");
    drain(2, "R5 wrap");
    post(16'h0, 8'h03, "R5 wrap from 3");
    drain(2, "R5 wrap from 3");

    // R8: lost arbitration reoffers the same buffer
    post(16'h0, 8'h12, "R8 retry");
    wait_grant("R8");
    finish(1'b1, 1'b0, "R8 lost");
    drain(2, "R8 after loss");

    // R9: done and lost while idle change nothing
    @(negedge clk);
    done_q = 1'b1;
    lost_q = 1'b1;
    #1;
    check(clr_tx == '0 && clr_rtr == '0, "R9 idle strobes", {8'd0, clr_rtr, clr_tx}, 32'd0);
    @(negedge clk);
    done_q = 1'b0;
    lost_q = 1'b0;
    check(g_valid == 1'b0, "R9 idle no grant", {31'd0, g_valid}, 32'd0);
    post(16'h0, 8'h0C, "R9 pointer unchanged");
    drain(2, "R9 pointer unchanged");

    // R4: fixed order
    rr = 1'b0;
    post(16'h0, 8'hA4, "R4 fixed");
    drain(3, "R4 fixed");

    // R3: remote lines outrank buffers, ascending
    post(16'h0300, 8'h01, "R3 remote first");
    drain(3, "R3 remote order");

    // R6: grant held while requests change
    post(16'h0, 8'h08, "R6 setup");
    wait_grant("R6");
    @(negedge clk);
    rtr_q = 16'h0001;
    tx_q  = 8'h09;
    repeat (3) begin
      @(negedge clk);
      check(g_valid && !g_rtr && g_idx == 4'd3, "R6 grant held",
            {27'd0, g_rtr, g_idx}, 32'h3);
    end
    finish(1'b0, 1'b0, "R6 then remote");
    drain(2, "R6 drain");

    // R9/R7: done and lost together act as done
    rr = 1'b1;
    post(16'h0, 8'h41, "R9 both setup");
    wait_grant("R9");
    finish(1'b0, 1'b1, "R9 both as done");
    drain(1, "R7 pointer advanced");

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R2 all expected grants seen", exp_q.size(), 32'd0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule